// File: doc/BRIEF.md
# Integer ALU with Condition Flags and Branch Test

This block is the execute-stage arithmetic unit of a small 32-bit processor. It takes the two register operands of an arithmetic or logical instruction together with a 4-bit function code. It returns the 32-bit result in the same cycle. Alongside the result it works out zero, sign and overflow flags, which are written into a flag register on the next rising clock edge when the flag-enable input is high.

A second path tests the stored flags against a 4-bit jump condition code and returns a take-branch bit. This lets a conditional jump be resolved from the flags that an earlier instruction left behind. Function codes outside the defined sets are reported on separate invalid outputs. An invalid ALU code never disturbs the flags, and an invalid jump code never takes the branch.

Top module: `flagged_alu`

## Requirements
- R1: ALU function code 0 drives result with (B + A) modulo 2^32, where A is `opnd_a` and B is `opnd_b`.
- R2: ALU function code 1 drives result with B minus A (modulo 2^32), the second operand less the first.
- R3: ALU function code 2 gives the bitwise AND of A and B, and code 3 gives their bitwise XOR.
- R4: When `flag_we` is high and the code is valid, the next rising edge stores zero = (result == 0) and sign = result bit 31 on `flag_z` and `flag_s`.
- R5: The stored overflow flag is set when the signed add (code 0) or the signed B minus A (code 1) falls outside the 32-bit two's-complement range. It is cleared by codes 2 and 3.
- R6: While `flag_we` is low, the flag outputs keep their values across clock edges whatever the ALU inputs do.
- R7: ALU codes 4 to 15 raise `alu_fn_bad`, drive result to zero and leave the flags unchanged even with `flag_we` high.
- R8: Reset (active-low `rst_n`, asserted asynchronously, released after two clock edges) sets zero=1, sign=0 and overflow=0.
- R9: `br_take` follows the stored flags for jump codes 0 (always), 1 (signed less-or-equal), 2 (signed less), 3 (equal), 4 (not equal), 5 (signed greater-or-equal) and 6 (signed greater). Less means sign XOR overflow, so after B minus A the branch matches the signed comparison of B against A.
- R10: Jump codes 7 to 15 raise `br_fn_bad` and hold `br_take` low.
- R11: In a cycle that both updates the flags and tests a jump, `br_take` reflects the flags held before the edge. The new flags steer it from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| opnd_a | input | 32 | First operand A (source register value) |
| opnd_b | input | 32 | Second operand B (destination register value) |
| alu_fn | input | 4 | ALU function code |
| flag_we | input | 1 | Flag register write enable |
| br_fn | input | 4 | Jump condition code |
| alu_res | output | 32 | Combinational ALU result |
| alu_fn_bad | output | 1 | ALU function code is undefined |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored sign flag |
| flag_o | output | 1 | Stored overflow flag |
| br_take | output | 1 | Branch condition holds |
| br_fn_bad | output | 1 | Jump condition code is undefined |

## Verification
A flag write and a branch test can fall in the same cycle. The test that resolves is then the one against the flags already held, while the register is loading new ones. The bench provokes this by setting the flags to "equal" and then presenting, in one cycle, a subtraction with a non-zero difference, a high write enable and the equal condition. It expects the branch taken before the edge and not taken after it. The jump conditions themselves are judged after every subtraction in the operand sweep, against a signed comparison of B with A that the bench computes.

// File: rtl/alufl_pkg.sv
package alufl_pkg;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    JC_ALWAYS = 4'd0,
    JC_LE     = 4'd1,
    JC_LT     = 4'd2,
    JC_EQ     = 4'd3,
    JC_NE     = 4'd4,
    JC_GE     = 4'd5,
    JC_GT     = 4'd6
  } jmp_fn_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  localparam flags_t FLAGS_RST = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alufl_rst_sync.sv
module alufl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/alufl_core.sv
module alufl_core
  import alufl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FN_W   = 4
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [FN_W-1:0]   fn,
  output logic [DATA_W-1:0] y,
  output flags_t            fl_nxt,
  output logic              fn_bad
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] dif;
  logic              add_ov;
  logic              sub_ov;

  always_comb begin
    sum    = b + a;
    dif    = b - a;
    // same-sign inputs whose sum flips sign
    add_ov = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
    // opposite-sign inputs where B-A does not keep B's sign
    sub_ov = (a[MSB] != b[MSB]) && (dif[MSB] != b[MSB]);
  end

  always_comb begin
    y         = '0;
    fn_bad    = 1'b0;
    fl_nxt.of = 1'b0;
    case (fn)
      FN_ADD: begin y = sum;   fl_nxt.of = add_ov; end
      FN_SUB: begin y = dif;   fl_nxt.of = sub_ov; end
      FN_AND: begin y = a & b; end
      FN_XOR: begin y = a ^ b; end
      default: fn_bad = 1'b1;
    endcase
    fl_nxt.zf = (y == '0);
    fl_nxt.sf = y[MSB];
  end

  always_comb begin
    if (fn_bad) assert (y == '0) else $error("p_bad_zero_r7 failed");
  end
endmodule

// File: rtl/alufl_flag_reg.sv
module alufl_flag_reg
  import alufl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   upd,
  input  flags_t d,
  output flags_t q
);
  flags_t q_nxt;

  always_comb begin
    q_nxt = upd ? d : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= FLAGS_RST;
    else        q <= q_nxt;
  end

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(q));
endmodule

// File: rtl/alufl_cond.sv
module alufl_cond
  import alufl_pkg::*;
#(
  parameter int FN_W = 4
) (
  input  flags_t          fl,
  input  logic [FN_W-1:0] jfn,
  output logic            take,
  output logic            jbad
);
  logic lt;

  always_comb begin
    lt   = fl.sf ^ fl.of;
    take = 1'b0;
    jbad = 1'b0;
    case (jfn)
      JC_ALWAYS: take = 1'b1;
      JC_LE:     take = lt | fl.zf;
      JC_LT:     take = lt;
      JC_EQ:     take = fl.zf;
      JC_NE:     take = ~fl.zf;
      JC_GE:     take = ~lt;
      JC_GT:     take = ~lt & ~fl.zf;
      default:   jbad = 1'b1;
    endcase
  end
endmodule

// File: rtl/flagged_alu.sv
module flagged_alu
  import alufl_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int FN_W        = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [FN_W-1:0]   alu_fn,
  input  logic              flag_we,
  input  logic [FN_W-1:0]   br_fn,
  output logic [DATA_W-1:0] alu_res,
  output logic              alu_fn_bad,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o,
  output logic              br_take,
  output logic              br_fn_bad
);
  logic   rst_int_n;
  flags_t fl_nxt;
  flags_t fl_q;
  logic   fl_upd;

  alufl_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .arst_n     (rst_n),
    .rst_n_sync (rst_int_n)
  );

  alufl_core #(.DATA_W(DATA_W), .FN_W(FN_W)) u_core (
    .a      (opnd_a),
    .b      (opnd_b),
    .fn     (alu_fn),
    .y      (alu_res),
    .fl_nxt (fl_nxt),
    .fn_bad (alu_fn_bad)
  );

  assign fl_upd = flag_we & ~alu_fn_bad;

  alufl_flag_reg u_flags (
    .clk   (clk),
    .rst_n (rst_int_n),
    .upd   (fl_upd),
    .d     (fl_nxt),
    .q     (fl_q)
  );

  alufl_cond #(.FN_W(FN_W)) u_cond (
    .fl   (fl_q),
    .jfn  (br_fn),
    .take (br_take),
    .jbad (br_fn_bad)
  );

  assign flag_z = fl_q.zf;
  assign flag_s = fl_q.sf;
  assign flag_o = fl_q.of;

  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_we && !alu_fn_bad) |=>
      (flag_z == ($past(alu_res) == '0)) && (flag_s == $past(alu_res[DATA_W-1])));

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (flag_we && (alu_fn == FN_AND || alu_fn == FN_XOR)) |=> !flag_o);

  p_bad_keeps_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    alu_fn_bad |=> $stable({flag_z, flag_s, flag_o}));

  p_eq_follows_z_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_fn == JC_EQ) |-> (br_take == flag_z));

  p_bad_jump_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    br_fn_bad |-> !br_take);

  p_old_flags_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    (br_fn == JC_NE) |=> ($past(br_take) == !$past(flag_z)));
endmodule

// File: tb/flagged_alu_bench.sv
module flagged_alu_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] opnd_a, opnd_b;
  logic [3:0]  alu_fn, br_fn;
  logic        flag_we;
  logic [31:0] alu_res;
  logic        alu_fn_bad, flag_z, flag_s, flag_o, br_take, br_fn_bad;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  flagged_alu u_flagged_alu (
    .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .alu_fn(alu_fn), .flag_we(flag_we), .br_fn(br_fn),
    .alu_res(alu_res), .alu_fn_bad(alu_fn_bad), .flag_z(flag_z),
    .flag_s(flag_s), .flag_o(flag_o), .br_take(br_take), .br_fn_bad(br_fn_bad)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h1234_5678;
      6: return 32'hDEAD_BEEF;
      7: return 32'h4000_0000;
      8: return 32'hC000_0000;
      default: return 32'h0000_ABCD;
    endcase
  endfunction

  // expected values computed with wide signed arithmetic
  task automatic run_vec(input logic [31:0] a, input logic [31:0] b, input int fn);
    longint sa, sb, wide;
    logic [31:0] er;
    bit eo;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    eo = 1'b0;
    case (fn)
      0: begin wide = sb + sa; er = b + a; eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      1: begin wide = sb - sa; er = b - a; eo = (wide > 64'sd2147483647) || (wide < -64'sd2147483648); end
      2: er = a & b;
      default: er = a ^ b;
    endcase
    @(negedge clk);
    opnd_a = a; opnd_b = b; alu_fn = 4'(fn); flag_we = 1'b1; br_fn = 4'd0;
    #1;
    case (fn)
      0: chk(alu_res == er, "R1 add", alu_res, er);
      1: chk(alu_res == er, "R2 sub", alu_res, er);
      default: chk(alu_res == er, "R3 logic", alu_res, er);
    endcase
    @(negedge clk);
    flag_we = 1'b0;
    chk(flag_z == (er == 32'd0) && flag_s == er[31], "R4 zero/sign",
        {flag_z, flag_s}, {(er == 32'd0), er[31]});
    chk(flag_o == eo, "R5 overflow", flag_o, eo);
    if (fn == 1) begin
      for (int j = 0; j < 16; j++) begin
        bit et;
        br_fn = 4'(j);
        case (j)
          0: et = 1'b1;
          1: et = sb <= sa;
          2: et = sb <  sa;
          3: et = sb == sa;
          4: et = sb != sa;
          5: et = sb >= sa;
          6: et = sb >  sa;
          default: et = 1'b0;
        endcase
        #1;
        if (j < 7) chk(br_take == et && !br_fn_bad, "R9 jump", {br_fn_bad, br_take}, et);
        else       chk(br_take == 1'b0 && br_fn_bad, "R10 bad jump", {br_fn_bad, br_take}, 2'b10);
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    logic [2:0] held;
    rst_n = 1'b1; opnd_a = '0; opnd_b = '0; alu_fn = '0; flag_we = 1'b0; br_fn = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({flag_z, flag_s, flag_o} == 3'b100, "R8 reset during", {flag_z, flag_s, flag_o}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({flag_z, flag_s, flag_o} == 3'b100, "R8 reset after", {flag_z, flag_s, flag_o}, 3'b100);
    // reset flags: Z=1 S=0 O=0 -> take pattern for codes 0..6
    for (int j = 0; j < 7; j++) begin
      logic [6:0] pat;
      pat = 7'b0101011;
      br_fn = 4'(j);
      #1;
      chk(br_take == pat[j], "R9 reset flags", br_take, pat[j]);
    end

    // operand sweep
    for (int i = 0; i < 10; i++)
      for (int k = 0; k < 10; k++)
        for (int f = 0; f < 4; f++)
          run_vec(pick(i), pick(k), f);

    // R6: write enable low keeps flags
    run_vec(32'd3, 32'd1, 1); // -2: Z=0 S=1 O=0
    held = {flag_z, flag_s, flag_o};
    @(negedge clk);
    opnd_a = 32'd5; opnd_b = 32'd5; alu_fn = 4'd1; flag_we = 1'b0;
    repeat (2) @(negedge clk);
    chk({flag_z, flag_s, flag_o} == held, "R6 hold", {flag_z, flag_s, flag_o}, held);

    // R7: undefined ALU codes
    for (int f = 4; f < 16; f++) begin
      @(negedge clk);
      opnd_a = 32'd7; opnd_b = 32'd7; alu_fn = 4'(f); flag_we = 1'b1;
      #1;
      chk(alu_fn_bad && alu_res == 32'd0, "R7 bad fn result", {alu_fn_bad, alu_res}, {1'b1, 32'd0});
      @(negedge clk);
      chk({flag_z, flag_s, flag_o} == held, "R7 flags kept", {flag_z, flag_s, flag_o}, held);
    end
    flag_we = 1'b0;

    // R11: flag write and branch test in one cycle
    run_vec(32'd5, 32'd5, 1); // Z=1
    @(negedge clk);
    opnd_a = 32'd1; opnd_b = 32'd5; alu_fn = 4'd1; flag_we = 1'b1; br_fn = 4'd3;
    #1;
    chk(br_take == 1'b1, "R11 old flags", br_take, 1'b1);
    @(negedge clk);
    flag_we = 1'b0;
    chk(br_take == 1'b0, "R11 new flags", br_take, 1'b0);

    finish_run();
  end
endmodule